// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip: a 16-state test access port controller steered by a mode-select serial input, a 3-bit instruction register, and three data registers (a 1-bit bypass stage, a 32-bit identification register and a boundary register of parameterised length). The instruction in force decides which data register is placed between the serial input and the serial output, whether the boundary register drives a parallel output vector, and whether the functional outputs of the chip should be forced to high impedance.

There is no dedicated test reset pin. The controller returns to its reset state when the mode-select input is held high for five rising test-clock edges. It also resets while the chip-level power-on reset `rst_ni` is low. Serial and mode inputs are sampled on the rising test clock. The serial output and its enable change on the falling test clock. The boundary register captures a generic parallel input vector and drives a generic parallel output vector. It models no pad ring.

Top module: `scan_tap`

## Requirements
- R1: While `rst_ni` is low and after its release, the controller is in Test-Logic-Reset, the identification instruction (001) is active, `tdo_oe_o`, `bnd_drive_o` and `func_hiz_o` are 0, and a first data scan returns the identification code.
- R2: Five consecutive rising `tck_i` edges with `tms_i` high bring the controller to Test-Logic-Reset from any state, and the instruction then returns to identification (001).
- R3: State transitions follow the standard 16-state graph, with `tms_i` and `tdi_i` sampled on rising `tck_i`.
- R4: `tdo_o` and `tdo_oe_o` update on falling `tck_i`. `tdo_oe_o` is 1 only while in Shift-IR or Shift-DR. Registers shift toward bit 0, so bit 0 leaves first and `tdi_i` enters at the top bit.
- R5: Capture-IR loads 3'b001, so the first three bits shifted out of the instruction register are 1, 0, 0.
- R6: A shifted instruction takes effect only at the clock edge that ends Update-IR. Before that edge the previous instruction still controls `func_hiz_o`, `bnd_drive_o` and the data path.
- R7: Instruction decode: 001 selects identification; 000, 010 and 100 select the boundary register; 011, 101, 110 and 111 select bypass.
- R8: The identification register loads the parameter `ID_CODE` with bit 0 forced to 1 in Capture-DR, and shifts 32 bits with bit 0 first.
- R9: The bypass stage loads 0 in Capture-DR and then delays `tdi_i` by exactly one shift.
- R10: The boundary register loads `bnd_pin_i` in Capture-DR and shifts `BSR_W` bits. Update-DR with a boundary instruction copies the shifted value to `bnd_pin_o`, which otherwise holds its value.
- R11: `bnd_drive_o` is 1 exactly when instruction 000 is active. `func_hiz_o` is 1 exactly when instruction 010 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| tms_i | input | 1 | Mode select, sampled on rising tck_i |
| tdi_i | input | 1 | Serial data in, sampled on rising tck_i |
| tdo_o | output | 1 | Serial data out, updated on falling tck_i |
| tdo_oe_o | output | 1 | Serial output enable, high only in shift states |
| bnd_pin_i | input | BSR_W | Parallel vector captured by the boundary register |
| bnd_pin_o | output | BSR_W | Boundary update latch contents |
| bnd_drive_o | output | 1 | bnd_pin_o is meant to drive (external test active) |
| func_hiz_o | output | 1 | Force functional outputs to high impedance |

## Verification
A wrong controller state shows up at the ports within one falling edge: `tdo_oe_o` either opens outside a shift state or stays closed inside one, and the serial stream slips by a bit. A wrong instruction decode is visible right after Update-IR, through `func_hiz_o` or `bnd_drive_o` or through the length and contents of the next data scan. The identification code, the leading 0 of bypass and the captured boundary vector each appear in the first bits shifted out. A broken five-high reset therefore shows in the very next scan, which returns something other than the identification code.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BND} dr_path_e;

  localparam logic [IR_W-1:0] OP_EXT = 3'b000;
  localparam logic [IR_W-1:0] OP_IDC = 3'b001;
  localparam logic [IR_W-1:0] OP_SMZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SMP = 3'b100;
  localparam logic [IR_W-1:0] OP_BYP = 3'b111;
  localparam logic [IR_W-1:0] IR_CAP = 3'b001;

  function automatic dr_path_e path_of(logic [IR_W-1:0] op);
    case (op)
      OP_IDC:                 return PATH_ID;
      OP_EXT, OP_SMZ, OP_SMP: return PATH_BND;
      default:                return PATH_BYP;
    endcase
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: state_d = tms_i ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: state_d = tms_i ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;

  assign state_o = state_q;

  // R2
  five_high_reset_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
    |=> state_q == ST_TLR);

  // R3
  shift_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_SHF_DR && !tms_i) |=> state_q == ST_SHF_DR);

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tdi_i,
  input  tap_state_e      state_i,
  output logic [IR_W-1:0] ir_o,
  output logic            ir_lsb_o
);
  logic [IR_W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      sh_q <= IR_CAP;
      ir_q <= OP_IDC;
    end else begin
      case (state_i)
        ST_CAP_IR: sh_q <= IR_CAP;
        ST_SHF_IR: sh_q <= {tdi_i, sh_q[IR_W-1:1]};
        default:   sh_q <= sh_q;
      endcase
      if (state_i == ST_TLR)         ir_q <= OP_IDC;
      else if (state_i == ST_UPD_IR) ir_q <= sh_q;
    end

  assign ir_o     = ir_q;
  assign ir_lsb_o = sh_q[0];

  // R5
  ir_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_IR |=> sh_q[1:0] == 2'b01);

  // R6
  ir_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_IR && state_i != ST_TLR) |=> $stable(ir_q));

  // R2
  ir_reset_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> ir_q == OP_IDC);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W   = 8,
  parameter logic [31:0] ID_CODE = 32'h0A5C_E0D3
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tdi_i,
  input  tap_state_e       state_i,
  input  dr_path_e         path_i,
  input  logic [BSR_W-1:0] bnd_pin_i,
  output logic [BSR_W-1:0] bnd_upd_o,
  output logic             dr_lsb_o
);
  localparam int          ID_W   = 32;
  localparam logic [31:0] ID_VAL = {ID_CODE[31:1], 1'b1};

  logic             byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_W-1:0] bsh_q, bupd_q, bsh_nxt;

  generate
    if (BSR_W > 1) begin : g_wide
      assign bsh_nxt = {tdi_i, bsh_q[BSR_W-1:1]};
    end else begin : g_single
      assign bsh_nxt = tdi_i;
    end
  endgenerate

  always_ff @(posedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      byp_q  <= 1'b0;
      id_q   <= ID_VAL;
      bsh_q  <= '0;
      bupd_q <= '0;
    end else begin
      case (path_i)
        PATH_BYP: begin
          if (state_i == ST_CAP_DR)      byp_q <= 1'b0;
          else if (state_i == ST_SHF_DR) byp_q <= tdi_i;
        end
        PATH_ID: begin
          if (state_i == ST_CAP_DR)      id_q <= ID_VAL;
          else if (state_i == ST_SHF_DR) id_q <= {tdi_i, id_q[ID_W-1:1]};
        end
        PATH_BND: begin
          if (state_i == ST_CAP_DR)      bsh_q  <= bnd_pin_i;
          else if (state_i == ST_SHF_DR) bsh_q  <= bsh_nxt;
          else if (state_i == ST_UPD_DR) bupd_q <= bsh_q;
        end
        default: ;
      endcase
    end

  always_comb
    case (path_i)
      PATH_ID:  dr_lsb_o = id_q[0];
      PATH_BND: dr_lsb_o = bsh_q[0];
      default:  dr_lsb_o = byp_q;
    endcase

  assign bnd_upd_o = bupd_q;

  // R8
  id_capture_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_CAP_DR && path_i == PATH_ID) |=> id_q[0] == 1'b1);

  // R9
  byp_delay_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_SHF_DR && path_i == PATH_BYP) |=> byp_q == $past(tdi_i));

  // R10
  bnd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i == ST_UPD_DR && path_i == PATH_BND) |=> $stable(bupd_q));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int          BSR_W   = 8,
  parameter logic [31:0] ID_CODE = 32'h0A5C_E0D3
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             tdo_oe_o,
  input  logic [BSR_W-1:0] bnd_pin_i,
  output logic [BSR_W-1:0] bnd_pin_o,
  output logic             bnd_drive_o,
  output logic             func_hiz_o
);
  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_lsb, dr_lsb;
  dr_path_e        path;
  logic            tdo_q, oe_q;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(state)
  );

  tap_ir u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tdi_i   (tdi_i),
    .state_i (state),
    .ir_o    (ir),
    .ir_lsb_o(ir_lsb)
  );

  assign path = path_of(ir);

  tap_dr #(.BSR_W(BSR_W), .ID_CODE(ID_CODE)) u_dr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state),
    .path_i   (path),
    .bnd_pin_i(bnd_pin_i),
    .bnd_upd_o(bnd_pin_o),
    .dr_lsb_o (dr_lsb)
  );

  // output stage on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni)
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= (state == ST_SHF_IR) ? ir_lsb : dr_lsb;
      oe_q  <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
    end

  assign tdo_o       = tdo_q;
  assign tdo_oe_o    = oe_q;
  assign bnd_drive_o = (ir == OP_EXT);
  assign func_hiz_o  = (ir == OP_SMZ);

  // R4
  oe_shift_only_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o |-> (state == ST_SHF_DR || state == ST_SHF_IR));

  // R11
  mode_excl_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({bnd_drive_o, func_hiz_o}));

endmodule

// File: tb/sim_scan_tap.sv
`timescale 1ns/1ps
module sim_scan_tap;
  localparam int          BW  = 8;
  localparam logic [31:0] IDV = 32'h0A5C_E0D3;
  localparam logic [63:0] IN_PAT = 64'hC3A5_96F0_5A1E_7B2D;

  // {code, path(0 byp,1 id,2 bnd), hiz, drive}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd2, 1'b0, 1'b1},
    {3'b001, 2'd1, 1'b0, 1'b0},
    {3'b010, 2'd2, 1'b1, 1'b0},
    {3'b011, 2'd0, 1'b0, 1'b0},
    {3'b100, 2'd2, 1'b0, 1'b0},
    {3'b101, 2'd0, 1'b0, 1'b0},
    {3'b110, 2'd0, 1'b0, 1'b0},
    {3'b111, 2'd0, 1'b0, 1'b0}
  };

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b1;
  logic tdo, tdo_oe, drv, hiz;
  logic [BW-1:0] pin_i = '0, pin_o;
  int n_chk = 0, n_fail = 0;

  always #5 tck = ~tck;

  scan_tap #(.BSR_W(BW), .ID_CODE(IDV)) u0 (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_oe_o(tdo_oe), .bnd_pin_i(pin_i), .bnd_pin_o(pin_o),
    .bnd_drive_o(drv), .func_hiz_o(hiz)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic q, output logic oe);
    @(negedge tck); #2;
    tms = m; tdi = d; q = tdo; oe = tdo_oe;
    @(posedge tck); #2;
  endtask

  task automatic go(input logic m);
    logic q, oe;
    step(m, 1'b1, q, oe);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout, output bit oe_all);
    logic q, oe;
    dout = '0; oe_all = 1;
    go(1); go(0); go(0);
    for (int k = 0; k < n; k++) begin
      step(k == n - 1, din[k], q, oe);
      dout[k] = q;
      if (!oe) oe_all = 0;
    end
    go(1); go(0);
  endtask

  task automatic ir_load(input logic [2:0] code, output logic [2:0] cap);
    logic q, oe;
    go(1); go(1); go(0); go(0);
    for (int k = 0; k < 3; k++) begin
      step(k == 2, code[k], q, oe);
      cap[k] = q;
    end
    go(1); go(0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] dout, expv, mask;
    logic [2:0] cap;
    bit oe_all;
    int n;
    repeat (3) @(posedge tck);
    #2;
    // R1 reset state
    chk(tdo_oe == 0 && hiz == 0 && drv == 0, "R1 reset outputs",
        {tdo_oe, hiz, drv}, 0);
    @(negedge tck); rst_n = 1'b1;
    go(0);
    scan_dr(32, IN_PAT, dout, oe_all);
    chk(dout[31:0] == {IDV[31:1], 1'b1}, "R1 R8 first scan id", dout, {IDV[31:1], 1'b1});

    // table walk: R5 R7 R8 R9 R10 R11 R4
    for (int i = 0; i < 8; i++) begin
      logic [2:0] code;
      logic [1:0] pth;
      code = VEC[i][6:4]; pth = VEC[i][3:2];
      ir_load(code, cap);
      chk(cap == 3'b001, "R5 capture-ir", cap, 3'b001);
      chk(hiz == VEC[i][1], "R11 hiz", hiz, VEC[i][1]);
      chk(drv == VEC[i][0], "R11 drive", drv, VEC[i][0]);
      pin_i = 8'h3C ^ {5'b0, code};
      n = (pth == 2'd1) ? 32 : (pth == 2'd2) ? BW : 4;
      case (pth)
        2'd1:    expv = {32'b0, IDV[31:1], 1'b1};
        2'd2:    expv = {56'b0, pin_i};
        default: expv = {60'b0, IN_PAT[2:0], 1'b0};
      endcase
      scan_dr(n, IN_PAT, dout, oe_all);
      mask = (64'd1 << n) - 64'd1;
      chk((dout & mask) == expv, "R7 R8 R9 R10 scan path", dout & mask, expv);
      chk(oe_all, "R4 oe during shift", {63'b0, oe_all}, 1);
      chk(tdo_oe == 0, "R4 oe idle", tdo_oe, 0);
      if (pth == 2'd2)
        chk(pin_o == IN_PAT[BW-1:0], "R10 update", pin_o, IN_PAT[BW-1:0]);
    end

    // R6: new code not active before Update-IR ends
    begin
      logic q, oe;
      ir_load(3'b111, cap);
      go(1); go(1); go(0); go(0);
      step(0, 1'b0, q, oe); step(0, 1'b1, q, oe); step(1, 1'b0, q, oe);
      chk(hiz == 0, "R6 exit1-ir", hiz, 0);
      go(1);
      chk(hiz == 0, "R6 in update-ir", hiz, 0);
      go(0);
      chk(hiz == 1, "R6 after update-ir", hiz, 1);
    end

    // R10: pin_o holds while not updating under boundary path
    pin_i = 8'hFF;
    scan_dr(BW, 64'h0, dout, oe_all);
    chk(pin_o == 8'h00, "R10 reload", pin_o, 8'h00);
    ir_load(3'b001, cap);
    scan_dr(32, IN_PAT, dout, oe_all);
    chk(pin_o == 8'h00, "R10 hold under id", pin_o, 8'h00);

    // R2: five highs from Shift-DR
    ir_load(3'b010, cap);
    go(1); go(0); go(0);
    repeat (5) go(1);
    go(0);
    chk(hiz == 0 && drv == 0, "R2 ir back to id", {hiz, drv}, 0);
    scan_dr(32, IN_PAT, dout, oe_all);
    chk(dout[31:0] == {IDV[31:1], 1'b1}, "R2 R3 id after reset", dout, {IDV[31:1], 1'b1});

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule